// File: doc/BRIEF.md
# Configurable Power-Up Reset Sequencer

This block merges three reasons to hold a chip in reset into one active-high internal reset. The reasons are a power-good flag, a supply-droop comparator flag, and an active-low reset pin. After every reason has cleared, the block keeps the reset asserted for a start-up delay. Configuration bits choose that delay. The block is fully digital: the analog comparators and oscillators outside it appear here only as single-bit flags.

The external pin has two roles, selected by a configuration bit. In reset mode it is filtered, so that only a low level held over consecutive clock samples counts, and the pad pull-up is requested. In general-purpose mode the pin never causes a reset, the pull-up is released, and the pin level is passed through on an input path. The delay is looked up from two select bits and a bit that marks the clock source as crystal or RC/external. The lookup gives a value in microseconds, which a clock-rate parameter turns into cycles.

A three-state machine does the sequencing. HOLD means a source is active. WAIT means the delay is counting. RUN means the reset is released. Transitions:
- Any state goes to HOLD whenever a source is active. This also happens asynchronously when power-good drops.
- HOLD goes to WAIT once no source is active.
- WAIT goes to RUN once the full delay has elapsed.

Configuration is captured only outside RUN.

Top module: `supply_reset_seq`

## Requirements
- R1: While the power-good input is low, the reset output is 1. On the first clock after power-good returns high, the reset output is still 1.
- R2: With supply-droop detection enabled in the captured configuration, the reset output is 1 in the same cycle the droop flag is 1, with no clock edge needed.
- R3: With supply-droop detection disabled in the captured configuration, the droop flag has no effect on the reset output.
- R4: In reset-pin mode (pin-enable bit 1), a pin level of 0 sampled at two consecutive rising edges asserts reset after the second edge. Reset stays asserted while the pin stays low. Once the pin returns high, release comes lim+2 edges later, where lim is the delay in cycles.
- R5: In reset-pin mode, a pin low for only one sampled edge causes no reset.
- R6: In general-purpose mode (pin-enable bit 0), the pin never causes reset and the general-purpose output equals the pin level. In reset-pin mode that output is 0.
- R7: The pull-up output equals the captured pin-enable bit.
- R8: The delay in microseconds is given by the clock-type bit (0 = RC/external, 1 = crystal) and the select bits sel[1:0]. For RC/external, 00/01/10/11 give 16/512/1024/4096. For crystal they give 1024/2048/4096/16384. lim is this value times CYC_PER_US. Release comes lim+1 edges after power-good returns high.
- R9: A source that reasserts during the delay restarts it. Release comes only lim+1 edges after the last source clears.
- R10: Configuration inputs are captured only while the state is not RUN. Changes made in RUN are ignored until the next reset. A pin-mode reset taken in RUN therefore releases lim+3 edges after its second low sample, using the newly captured configuration.
- R11: The reset output falls only on the edge that moves the state from WAIT to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ok_i | input | 1 | Power-good flag, low forces reset (asynchronous) |
| bod_low_i | input | 1 | Supply below droop threshold |
| pin_raw_i | input | 1 | Raw level of the shared reset/GPIO pin |
| bod_en_i | input | 1 | Droop detection enable (configuration) |
| pin_en_i | input | 1 | 1 = pin is reset input, 0 = GPIO (configuration) |
| sut_sel_i | input | 2 | Start-up delay select (configuration) |
| clk_xtal_i | input | 1 | 1 = crystal clock source, 0 = RC/external (configuration) |
| rst_o | output | 1 | Internal active-high reset |
| pullup_o | output | 1 | Pin pull-up enable |
| gpio_o | output | 1 | Pin level in GPIO mode, 0 in reset-pin mode |

## Verification
The bench sets CYC_PER_US to 1, which makes each delay equal its microsecond value in cycles. This puts five table entries within one run, including the crystal maximum of 16384 cycles, alongside the 16-cycle RC minimum. PIN_MIN_LOW stays at 2, so the one-sample pin glitch and the two-sample trigger can be placed on exact edges. The short RC entry keeps the restart, pin-mode and configuration-freeze scenarios cheap, and a behavioural model compares all three outputs on every cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        S_HOLD = 2'd0,
        S_WAIT = 2'd1,
        S_RUN  = 2'd2
    } rst_state_t;

    typedef struct packed {
        logic       bod_en;
        logic       pin_en;
        logic       xtal;
        logic [1:0] sut;
    } rst_cfg_t;

    localparam int MAX_TMO_US = 16384;

    // start-up delay in microseconds
    function automatic int tmo_us(input logic xtal, input logic [1:0] sel);
        int v;
        unique case ({xtal, sel})
            3'b000:  v = 16;
            3'b001:  v = 512;
            3'b010:  v = 1024;
            3'b011:  v = 4096;
            3'b100:  v = 1024;
            3'b101:  v = 2048;
            3'b110:  v = 4096;
            default: v = MAX_TMO_US;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rstseq_cfg_latch.sv
module rstseq_cfg_latch
    import rstseq_pkg::*;
(
    input  logic     clk_i,
    input  logic     load_i,
    input  rst_cfg_t cfg_d_i,
    output rst_cfg_t cfg_q_o
);

    rst_cfg_t cfg_q;

    always_ff @(posedge clk_i) begin
        if (load_i) begin
            cfg_q <= cfg_d_i;
        end
    end

    assign cfg_q_o = cfg_q;

endmodule

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
    parameter int PIN_MIN_LOW = 2
) (
    input  logic clk_i,
    input  logic pin_i,
    input  logic pin_en_i,
    output logic hit_o,
    output logic pullup_o,
    output logic gpio_o
);

    localparam int RUN_W = $clog2(PIN_MIN_LOW + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(PIN_MIN_LOW);

    logic [RUN_W-1:0] low_run_q;

    // consecutive low samples, saturating
    always_ff @(posedge clk_i) begin
        if (pin_i) begin
            low_run_q <= '0;
        end else if (low_run_q != RUN_SAT) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    always_comb begin
        hit_o    = pin_en_i && (low_run_q == RUN_SAT);
        pullup_o = pin_en_i;
        gpio_o   = pin_en_i ? 1'b0 : pin_i;
    end

endmodule

// File: rtl/rstseq_tmo_lut.sv
module rstseq_tmo_lut
    import rstseq_pkg::*;
#(
    parameter int CYC_PER_US = 20,
    parameter int LIM_W      = 19
) (
    input  logic             xtal_i,
    input  logic [1:0]       sel_i,
    output logic [LIM_W-1:0] limit_o
);

    generate
        if (CYC_PER_US == 1) begin : g_unit
            always_comb limit_o = LIM_W'(tmo_us(xtal_i, sel_i));
        end else begin : g_scaled
            always_comb limit_o = LIM_W'(tmo_us(xtal_i, sel_i) * CYC_PER_US);
        end
    endgenerate

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int LIM_W = 19
) (
    input  logic             clk_i,
    input  logic             por_ok_i,
    input  logic             src_i,
    input  logic [LIM_W-1:0] limit_i,
    output rst_state_t       state_o,
    output logic             rst_o
);

    rst_state_t       state_q, state_d;
    logic [LIM_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i or negedge por_ok_i) begin
        if (!por_ok_i) begin
            state_q <= S_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_HOLD: begin
                cnt_d = '0;
                if (!src_i) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (src_i) begin
                    state_d = S_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == limit_i - 1'b1) begin
                    state_d = S_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_RUN: begin
                if (src_i) begin
                    state_d = S_HOLD;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = S_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        rst_o   = (state_q != S_RUN) || src_i;
        state_o = state_q;
    end

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import rstseq_pkg::*;
#(
    parameter int CYC_PER_US  = 20,
    parameter int PIN_MIN_LOW = 2
) (
    input  logic       clk_i,
    input  logic       por_ok_i,
    input  logic       bod_low_i,
    input  logic       pin_raw_i,
    input  logic       bod_en_i,
    input  logic       pin_en_i,
    input  logic [1:0] sut_sel_i,
    input  logic       clk_xtal_i,
    output logic       rst_o,
    output logic       pullup_o,
    output logic       gpio_o
);

    localparam int LIM_W = $clog2(MAX_TMO_US * CYC_PER_US + 1);

    rst_state_t       state_w;
    rst_cfg_t         cfg_d, cfg_q;
    logic             pin_hit;
    logic             src_w;
    logic [LIM_W-1:0] limit_w;

    always_comb begin
        cfg_d.bod_en = bod_en_i;
        cfg_d.pin_en = pin_en_i;
        cfg_d.xtal   = clk_xtal_i;
        cfg_d.sut    = sut_sel_i;
    end

    rstseq_cfg_latch u_cfg (
        .clk_i   (clk_i),
        .load_i  (state_w != S_RUN),
        .cfg_d_i (cfg_d),
        .cfg_q_o (cfg_q)
    );

    rstseq_pin_filter #(
        .PIN_MIN_LOW (PIN_MIN_LOW)
    ) u_pin (
        .clk_i    (clk_i),
        .pin_i    (pin_raw_i),
        .pin_en_i (cfg_q.pin_en),
        .hit_o    (pin_hit),
        .pullup_o (pullup_o),
        .gpio_o   (gpio_o)
    );

    rstseq_tmo_lut #(
        .CYC_PER_US (CYC_PER_US),
        .LIM_W      (LIM_W)
    ) u_lut (
        .xtal_i  (cfg_q.xtal),
        .sel_i   (cfg_q.sut),
        .limit_o (limit_w)
    );

    assign src_w = !por_ok_i || (cfg_q.bod_en && bod_low_i) || pin_hit;

    rstseq_fsm #(
        .LIM_W (LIM_W)
    ) u_fsm (
        .clk_i    (clk_i),
        .por_ok_i (por_ok_i),
        .src_i    (src_w),
        .limit_i  (limit_w),
        .state_o  (state_w),
        .rst_o    (rst_o)
    );

endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk
    import rstseq_pkg::*;
(
    input logic       clk_i,
    input logic       por_ok_i,
    input logic       bod_low_i,
    input logic       pin_raw_i,
    input logic       rst_o,
    input logic       pullup_o,
    input logic       src_i,
    input rst_state_t state_i,
    input rst_cfg_t   cfg_i
);

    a_r1_held_after_power_return: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        $rose(por_ok_i) |-> rst_o);

    a_r2_droop_immediate: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        (cfg_i.bod_en && bod_low_i) |-> rst_o);

    a_r5_single_low_ignored: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        (state_i == S_RUN && !(cfg_i.bod_en && bod_low_i) && $past(pin_raw_i)) |=> (state_i == S_RUN));

    a_r7_pullup_steady_in_run: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        (state_i == S_RUN && $past(state_i) == S_RUN) |-> $stable(pullup_o));

    a_r9_restart_on_source: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        (state_i == S_WAIT && src_i) |=> (state_i == S_HOLD));

    a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        (!rst_o && !$past(rst_o)) |-> $stable(cfg_i));

    a_r11_release_from_wait: assert property (@(posedge clk_i) disable iff (!por_ok_i)
        $fell(rst_o) |-> ($past(state_i) == S_WAIT));

endmodule

bind supply_reset_seq supply_reset_seq_chk chk_i (
    .clk_i     (clk_i),
    .por_ok_i  (por_ok_i),
    .bod_low_i (bod_low_i),
    .pin_raw_i (pin_raw_i),
    .rst_o     (rst_o),
    .pullup_o  (pullup_o),
    .src_i     (src_w),
    .state_i   (state_w),
    .cfg_i     (cfg_q)
);

// File: tb/supply_reset_seq_tb_top.sv
`timescale 1ns/1ps
module supply_reset_seq_tb_top;

    localparam int CPU = 1;

    logic       clk = 1'b0;
    logic       por_ok, bod_low, pin_raw, bod_en, pin_en, xtal;
    logic [1:0] sut;
    logic       rst_o, pullup_o, gpio_o;
    int         checks = 0;
    int         errors = 0;
    bit         armed = 1'b0;

    always #2.5 clk = ~clk;

    supply_reset_seq #(.CYC_PER_US(CPU), .PIN_MIN_LOW(2)) dut_i (
        .clk_i(clk), .por_ok_i(por_ok), .bod_low_i(bod_low), .pin_raw_i(pin_raw),
        .bod_en_i(bod_en), .pin_en_i(pin_en), .sut_sel_i(sut), .clk_xtal_i(xtal),
        .rst_o(rst_o), .pullup_o(pullup_o), .gpio_o(gpio_o)
    );

    function automatic int table_us(bit x, bit [1:0] s);
        int rc[4] = '{16, 512, 1024, 4096};
        int xt[4] = '{1024, 2048, 4096, 16384};
        return x ? xt[s] : rc[s];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 held, 1 counting, 2 released
    int m_st = 0, m_cnt = 0, m_low = 0;
    bit m_bod, m_pin, m_xt;
    bit [1:0] m_sel;

    always @(posedge clk) begin
        bit src, samp;
        int lim;
        src  = !por_ok || (m_bod && bod_low) || (m_pin && m_low >= 2);
        lim  = table_us(m_xt, m_sel) * CPU;
        samp = (m_st != 2) || !por_ok;
        if (src) begin m_st = 0; m_cnt = 0; end
        else if (m_st == 0) begin m_st = 1; m_cnt = 0; end
        else if (m_st == 1) begin
            if (m_cnt == lim - 1) m_st = 2; else m_cnt++;
        end
        if (samp) begin m_bod = bod_en; m_pin = pin_en; m_xt = xtal; m_sel = sut; end
        m_low = pin_raw ? 0 : ((m_low < 2) ? m_low + 1 : 2);
    end

    always @(negedge clk) begin
        if (armed) begin
            bit e_rst;
            e_rst = (m_st != 2) || !por_ok || (m_bod && bod_low) || (m_pin && m_low >= 2);
            chk("R11 model rst", rst_o, e_rst);
            chk("R7 model pullup", pullup_o, m_pin);
            chk("R6 model gpio", gpio_o, m_pin ? 0 : pin_raw);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk); #2; n++;
        end while (rst_o && n < 40000);
    endtask

    task automatic power_up(input bit b, input bit p, input bit x, input bit [1:0] s);
        int n;
        bod_en = b; pin_en = p; xtal = x; sut = s;
        por_ok = 1'b0;
        cyc(4);
        chk("R1 held while power low", rst_o, 1);
        por_ok = 1'b1;
        measure(n);
        chk("R8 power-up delay", n, table_us(x, s) * CPU + 1);
        cyc(1);
    endtask

    initial begin
        int n;
        por_ok = 1'b1; bod_low = 0; pin_raw = 1; bod_en = 1; pin_en = 1; xtal = 0; sut = 2'b00;
        #1 por_ok = 1'b0;
        cyc(3);
        armed = 1'b1;
        por_ok = 1'b1;
        measure(n);
        chk("R1 first release", n, 16 * CPU + 1);
        cyc(1);

        power_up(1, 1, 1, 2'b00);
        power_up(1, 1, 0, 2'b11);
        power_up(1, 1, 1, 2'b01);
        power_up(1, 1, 0, 2'b00);
        chk("R7 pullup in pin mode", pullup_o, 1);
        chk("R6 gpio zero in pin mode", gpio_o, 0);

        // droop, same-cycle assertion
        bod_low = 1; #1;
        chk("R2 immediate", rst_o, 1);
        cyc(3); bod_low = 0;
        measure(n);
        chk("R2 release delay", n, 16 * CPU + 1);
        cyc(1);

        // single low sample
        pin_raw = 0; cyc(1); pin_raw = 1; cyc(3);
        chk("R5 glitch ignored", rst_o, 0);

        // pin held low
        pin_raw = 0; cyc(1);
        chk("R5 one sample", rst_o, 0);
        cyc(1);
        chk("R4 asserted", rst_o, 1);
        cyc(5);
        chk("R4 held", rst_o, 1);
        pin_raw = 1;
        measure(n);
        chk("R4 release delay", n, 16 * CPU + 2);
        cyc(1);

        // restart during delay (RC 01 = 512)
        sut = 2'b01; bod_low = 1; cyc(2); bod_low = 0;
        cyc(300);
        chk("R9 still counting", rst_o, 1);
        bod_low = 1; cyc(1); bod_low = 0;
        measure(n);
        chk("R9 full restart", n, 512 * CPU + 1);
        cyc(1);

        // droop ignored when disabled, GPIO mode
        power_up(0, 0, 0, 2'b00);
        chk("R7 pullup off", pullup_o, 0);
        bod_low = 1; pin_raw = 0; cyc(20);
        chk("R3 droop ignored", rst_o, 0);
        chk("R6 pin no reset", rst_o, 0);
        chk("R6 gpio low", gpio_o, 0);
        bod_low = 0; pin_raw = 1; #1;
        chk("R6 gpio high", gpio_o, 1);
        cyc(1);

        // configuration frozen in RUN
        power_up(1, 1, 0, 2'b00);
        pin_en = 0; xtal = 1; sut = 2'b11; cyc(5);
        chk("R10 pullup frozen", pullup_o, 1);
        chk("R10 no reset", rst_o, 0);
        pin_raw = 0; cyc(2);
        chk("R10 old pin mode", rst_o, 1);
        measure(n);
        chk("R10 new delay", n, 16384 * CPU + 3);
        pin_raw = 1; cyc(2);
        chk("R7 pullup after recapture", pullup_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired (R11) actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule